// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block is a fully associative address translation cache. A lookup request carries a 32-bit virtual address and a privilege flag. In the same cycle every stored entry compares the address against its own page number, under a compare mask set by that entry's own page size (1 KB up to 16 MB in steps of four). Entries can also be restricted to one address space through an 8-bit translation ID. When an entry matches, the block returns the physical address, the entry index and a read/write/execute permission vector one clock later. A 32-bit zone protection input can widen or remove the entry's own permissions, and the effect depends on the privilege mode.

Entries are loaded through a separate write port. Each write selects the tag word or the data word of one slot. A tag write also captures the translation ID driven alongside it. The host drives the current process ID and the zone protection word as plain inputs.

Top module: `vtlb_top`

## Requirements
- R1: Tag word layout: page number in bits [31:10], size code in bits [9:7], valid in bit 6. Size code s gives a page of 1 KB·4^s, so codes 0..7 give 1K, 4K, 16K, 64K, 256K, 1M, 4M and 16M. An entry matches only when the virtual address and the tag agree on every bit at or above bit 10+2s.
- R2: An entry whose valid bit (tag bit 6) is clear never hits.
- R3: An entry whose translation ID is zero matches under any process ID. A nonzero ID matches only when it equals `pid`.
- R4: When several entries match, the response reports the lowest matching index.
- R5: Data word layout: real page number in bits [31:10], execute in bit 9, write in bit 8, zone select in bits [7:4]. On a hit, the physical address is (data & 0xFFFFFC00) OR (virtual address bits below bit 10+2s), ANDed with the parameter `PA_MASK` (default 0x3FFFFFFF).
- R6: The zone field of zone z is `zpr[31-2z:30-2z]`. If z is greater than `ZONE_MAX` (default 11), or zones are disabled by parameter, the field is taken as 01. Under field 01, a hit grants read (prot bit 0), write (prot bit 1) from the data write bit and execute (prot bit 2) from the data execute bit.
- R7: Zone field 00 gives a user-mode hit prot 000 and sets `rsp_perr`. In supervisor mode it grants the entry bits as under 01.
- R8: Zone field 10 grants supervisor mode 111. User mode gets the entry bits.
- R9: Zone field 11 grants 111 in both modes.
- R10: Every output is registered. `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high. The other outputs update only then and hold otherwise. A miss reports hit 0, index 0, address 0, prot 000 and perr 0.
- R11: A tag write stores the tag and the translation ID on `wr_tid` together. A lookup issued in the same cycle as a write sees the contents from before that write.
- R12: After reset every entry is invalid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 1 | 0 = tag word, 1 = data word |
| wr_idx | input | 6 | Entry slot written |
| wr_data | input | 32 | Word written |
| wr_tid | input | 8 | Translation ID stored with a tag write |
| pid | input | 8 | Current process ID |
| zpr | input | 32 | Zone protection word, 2 bits per zone |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | 6 | Index of the matching entry |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_prot | output | 3 | {execute, write, read} granted |
| rsp_perr | output | 1 | Hit denied by zone protection |

## Verification
The assertions assume a well-formed write port: `wr_idx` stays below the entry count, and software loads an entry's data word before it sets the tag valid bit. The bench follows this order for every entry it builds. It never writes out of range, so no hit can read a data slot that was never written. The properties on the encoder and the output stage also assume that `pid`, `zpr` and `lk_user` are only sampled in the request cycle. The bench changes them only between lookups, except in the deliberate test where a write and a lookup fall in the same cycle.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int VA_W   = 32;
  localparam int BASE_SH = 10;

  typedef struct packed {
    logic [21:0] pnum;
    logic [2:0]  szc;
    logic        vld;
  } tag_t;

  typedef struct packed {
    logic [21:0] rnum;
    logic        xen;
    logic        wen;
    logic [3:0]  zsel;
  } dat_t;

  function automatic logic [VA_W-1:0] page_keep(input logic [2:0] code);
    return {VA_W{1'b1}} << (BASE_SH + 2 * int'(code));
  endfunction

endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        wr_tid,
  output tag_t              tags   [ENTRIES],
  output dat_t              dats   [ENTRIES],
  output logic [7:0]        tids   [ENTRIES]
);

  tag_t       tag_q [ENTRIES];
  dat_t       dat_q [ENTRIES];
  logic [7:0] tid_q [ENTRIES];

  // Tag side: reset clears valid so nothing hits before software loads it.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tid_q[i] <= '0;
      end
    end else if (wr_en && !wr_sel) begin
      tag_q[wr_idx] <= tag_t'(wr_data[31:6]);
      tid_q[wr_idx] <= wr_tid;
    end
  end

  // Data side: no reset, only consulted behind a valid tag.
  always_ff @(posedge clk) begin
    if (wr_en && wr_sel) begin
      dat_q[wr_idx] <= dat_t'(wr_data[31:4]);
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tags[i] = tag_q[i];
      dats[i] = dat_q[i];
      tids[i] = tid_q[i];
    end
  end

  AST_TID_FOLLOWS_TAG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> (tid_q[$past(wr_idx)] == $past(wr_tid))); // R11

endmodule

// File: rtl/vtlb_cam.sv
module vtlb_cam
  import vtlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  tag_t              tags [ENTRIES],
  input  logic [7:0]        tids [ENTRIES],
  input  logic [VA_W-1:0]   va,
  input  logic [7:0]        pid,
  output logic [ENTRIES-1:0] match
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_way
    logic [VA_W-1:0] keep;
    logic [VA_W-1:0] diff;
    logic            id_ok;
    assign keep  = page_keep(tags[g].szc);
    assign diff  = (va ^ {tags[g].pnum, {BASE_SH{1'b0}}}) & keep;
    assign id_ok = (tids[g] == 8'd0) || (tids[g] == pid);
    assign match[g] = tags[g].vld && (diff == '0) && id_ok;
  end

endmodule

// File: rtl/vtlb_pick.sv
module vtlb_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] match,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
    found = |match;
  end

  AST_PICK_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
    found |-> match[idx]); // R4
  AST_PICK_NONE_BELOW: assert property (@(posedge clk) disable iff (rst)
    found |-> ((match & ((ENTRIES'(1) << idx) - ENTRIES'(1))) == '0)); // R4

endmodule

// File: rtl/vtlb_prot.sv
module vtlb_prot #(
  parameter int ZONE_MAX = 11,
  parameter bit ZONES_ON = 1'b1
) (
  input  logic [3:0]  zsel,
  input  logic [31:0] zpr,
  input  logic        user,
  input  logic        ent_wr,
  input  logic        ent_ex,
  output logic [2:0]  prot,
  output logic        deny
);

  logic [31:0] shifted;
  logic [1:0]  field;
  logic [1:0]  eff;
  logic        g_wr;
  logic        g_ex;

  always_comb begin
    shifted = zpr >> (30 - 2 * int'(zsel));
    field   = shifted[1:0];
    if (!ZONES_ON || int'(zsel) > ZONE_MAX) eff = 2'b01;
    else                                    eff = field;

    g_wr = ent_wr;
    g_ex = ent_ex;
    deny = 1'b0;
    unique case (eff)
      2'b00: deny = user;
      2'b01: ;
      2'b10: if (!user) begin g_wr = 1'b1; g_ex = 1'b1; end
      2'b11: begin g_wr = 1'b1; g_ex = 1'b1; end
    endcase
    prot = deny ? 3'b000 : {g_ex, g_wr, 1'b1};
  end

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
  import vtlb_pkg::*;
#(
  parameter int          ENTRIES  = 64,
  parameter int          ZONE_MAX = 11,
  parameter bit          ZONES_ON = 1'b1,
  parameter logic [31:0] PA_MASK  = 32'h3FFF_FFFF,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        wr_tid,
  input  logic [7:0]        pid,
  input  logic [31:0]       zpr,
  input  logic              lk_req,
  input  logic [31:0]       lk_va,
  input  logic              lk_user,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [31:0]       rsp_paddr,
  output logic [2:0]        rsp_prot,
  output logic              rsp_perr
);

  tag_t               tags [ENTRIES];
  dat_t               dats [ENTRIES];
  logic [7:0]         tids [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic               found;
  logic [IDX_W-1:0]   win;
  logic [2:0]         win_sz;
  dat_t               win_dat;
  logic [31:0]        keep;
  logic [31:0]        pa_c;
  logic [2:0]         prot_c;
  logic               deny_c;

  vtlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_tid(wr_tid), .tags(tags), .dats(dats), .tids(tids)
  );

  vtlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .tags(tags), .tids(tids), .va(lk_va), .pid(pid), .match(match)
  );

  vtlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk(clk), .rst(rst), .match(match), .found(found), .idx(win)
  );

  assign win_sz  = tags[win].szc;
  assign win_dat = dats[win];
  assign keep    = page_keep(win_sz);
  assign pa_c    = ({win_dat.rnum, {BASE_SH{1'b0}}} | (lk_va & ~keep)) & PA_MASK;

  vtlb_prot #(.ZONE_MAX(ZONE_MAX), .ZONES_ON(ZONES_ON)) u_prot (
    .zsel(win_dat.zsel), .zpr(zpr), .user(lk_user),
    .ent_wr(win_dat.wen), .ent_ex(win_dat.xen), .prot(prot_c), .deny(deny_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_paddr <= '0;
      rsp_prot  <= '0;
      rsp_perr  <= 1'b0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit   <= found;
        rsp_idx   <= found ? win : '0;
        rsp_paddr <= found ? pa_c : '0;
        rsp_prot  <= found ? prot_c : 3'b000;
        rsp_perr  <= found && deny_c;
      end
    end
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> ($stable(rsp_hit) && $stable(rsp_paddr) && $stable(rsp_prot))); // R10
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_prot == 3'b000 && !rsp_perr && rsp_paddr == '0)); // R10
  AST_DENY_BLANKS_PROT: assert property (@(posedge clk) disable iff (rst)
    rsp_perr |-> (rsp_hit && rsp_prot == 3'b000)); // R7
  AST_HIT_READS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && !rsp_perr) |-> rsp_prot[0]); // R6

endmodule

// File: tb/sim_vtlb_top.sv
module sim_vtlb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  wr_tid = '0;
  logic [7:0]  pid = '0;
  logic [31:0] zpr = '0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_prot;
  logic        rsp_perr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vtlb_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_tid(wr_tid), .pid(pid), .zpr(zpr), .lk_req(lk_req),
    .lk_va(lk_va), .lk_user(lk_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot), .rsp_perr(rsp_perr)
  );

  // Reference model state
  logic [31:0] m_tag [64];
  logic [31:0] m_dat [64];
  logic [7:0]  m_tid [64];
  logic        e_hit;
  logic [5:0]  e_idx;
  logic [31:0] e_pa;
  logic [2:0]  e_prot;
  logic        e_perr;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Response strobe checked on every clock against a delayed copy of the request.
  logic exp_v = 1'b0;
  bit   run = 1'b0;
  always @(posedge clk) exp_v <= rst ? 1'b0 : lk_req;
  always @(negedge clk) if (run) chk("R10", "rsp_valid", 32'(rsp_valid), 32'(exp_v));

  task automatic model(input logic [31:0] va, input logic user);
    logic [31:0] off;
    logic [3:0]  z;
    logic [1:0]  f;
    logic        w, x;
    e_hit = 0; e_idx = 0; e_pa = 0; e_prot = 0; e_perr = 0;
    for (int i = 0; i < 64; i++) begin
      if (!e_hit && m_tag[i][6]) begin
        off = (32'd1024 << (2 * m_tag[i][9:7])) - 32'd1;
        if (((va & ~off) == (m_tag[i] & ~off)) && (m_tid[i] == 0 || m_tid[i] == pid)) begin
          e_hit = 1; e_idx = 6'(i);
          e_pa = ((m_dat[i] & 32'hFFFF_FC00) | (va & off)) & 32'h3FFF_FFFF;
          z = m_dat[i][7:4];
          f = (z > 11) ? 2'b01 : 2'((zpr >> (30 - 2 * z)) & 32'd3);
          w = m_dat[i][8]; x = m_dat[i][9];
          if (f == 2'b00 && user) e_perr = 1;
          if (f == 2'b10 && !user) begin w = 1; x = 1; end
          if (f == 2'b11) begin w = 1; x = 1; end
          e_prot = e_perr ? 3'b000 : {x, w, 1'b1};
        end
      end
    end
  endtask

  task automatic check_resp(input string req);
    chk(req, "hit", 32'(rsp_hit), 32'(e_hit));
    chk(req, "idx", 32'(rsp_idx), 32'(e_idx));
    chk(req, "paddr", rsp_paddr, e_pa);
    chk(req, "prot", 32'(rsp_prot), 32'(e_prot));
    chk(req, "perr", 32'(rsp_perr), 32'(e_perr));
  endtask

  task automatic wr(input logic sel, input int idx, input logic [31:0] d, input logic [7:0] tid);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = 6'(idx); wr_data = d; wr_tid = tid;
    if (sel) m_dat[idx] = d;
    else begin m_tag[idx] = d; m_tid[idx] = tid; end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(input int idx, input logic [31:0] epn, input int sz, input logic [7:0] tid,
                      input logic [31:0] rpn, input logic x, input logic w, input int zone);
    wr(1'b1, idx, (rpn & 32'hFFFF_FC00) | (32'(x) << 9) | (32'(w) << 8) | (32'(zone) << 4), 8'd0);
    wr(1'b0, idx, (epn & 32'hFFFF_FC00) | (32'(sz) << 7) | 32'h40, tid);
  endtask

  task automatic look(input logic [31:0] va, input logic user, input string req);
    @(negedge clk);
    model(va, user);
    lk_va = va; lk_user = user; lk_req = 1;
    @(negedge clk);
    lk_req = 0;
    check_resp(req);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_tag[i] = 0; m_dat[i] = 0; m_tid[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    run = 1;
    // R12: reset state
    chk("R12", "hit", 32'(rsp_hit), 0);
    chk("R12", "paddr", rsp_paddr, 0);
    chk("R12", "prot", 32'(rsp_prot), 0);
    look(32'h1234_5678, 1'b0, "R12");

    zpr = 32'h1B00_0000;  // zone0=00 zone1=01 zone2=10 zone3=11
    // R1 R5 R6: 4 KB page
    load(5, 32'h1234_5000, 1, 8'd0, 32'h0ABC_D000, 1'b0, 1'b1, 1);
    look(32'h1234_5678, 1'b1, "R1");
    look(32'h1234_6678, 1'b0, "R1");
    // R10: outputs hold while idle
    @(negedge clk); @(negedge clk);
    chk("R10", "hold hit", 32'(rsp_hit), 32'(e_hit));
    chk("R10", "hold paddr", rsp_paddr, e_pa);
    // R5: 16 MB page, address mask applied
    load(9, 32'h4000_0000, 7, 8'd0, 32'h8100_0000, 1'b1, 1'b1, 1);
    look(32'h40AB_CDEF, 1'b0, "R5");
    // R1: 1 KB page boundaries
    load(10, 32'h0000_0400, 0, 8'd0, 32'h0000_9000, 1'b0, 1'b0, 1);
    look(32'h0000_07FF, 1'b1, "R1");
    look(32'h0000_0800, 1'b1, "R1");
    look(32'h0000_03FF, 1'b1, "R1");
    // R3: translation ID filter
    load(12, 32'h2000_0000, 2, 8'h33, 32'h0001_0000, 1'b0, 1'b1, 1);
    pid = 8'h33;
    look(32'h2000_3ABC, 1'b0, "R3");
    pid = 8'h34;
    look(32'h2000_3ABC, 1'b0, "R3");
    look(32'h1234_5001, 1'b0, "R3");
    // R2: valid cleared
    wr(1'b0, 9, 32'h4000_0380, 8'd0);
    look(32'h40AB_CDEF, 1'b0, "R2");
    // R4: lowest index wins
    load(30, 32'h5000_0000, 1, 8'd0, 32'h3000_0000, 1'b1, 1'b1, 1);
    load(25, 32'h5000_0000, 1, 8'd0, 32'h2500_0000, 1'b0, 1'b0, 1);
    look(32'h5000_0123, 1'b0, "R4");
    load(26, 32'h5000_0000, 4, 8'd0, 32'h2600_0000, 1'b0, 1'b0, 1);
    look(32'h5000_0ABC, 1'b1, "R4");
    // Zones
    load(40, 32'h6000_0000, 1, 8'd0, 32'h0600_0000, 1'b1, 1'b1, 0);
    load(41, 32'h6100_0000, 1, 8'd0, 32'h0610_0000, 1'b0, 1'b0, 2);
    load(42, 32'h6200_0000, 1, 8'd0, 32'h0620_0000, 1'b0, 1'b0, 3);
    load(43, 32'h6300_0000, 1, 8'd0, 32'h0630_0000, 1'b1, 1'b0, 12);
    look(32'h6000_0010, 1'b1, "R7");
    look(32'h6000_0010, 1'b0, "R7");
    look(32'h6100_0010, 1'b0, "R8");
    look(32'h6100_0010, 1'b1, "R8");
    look(32'h6200_0010, 1'b1, "R9");
    look(32'h6200_0010, 1'b0, "R9");
    look(32'h6300_0010, 1'b1, "R6");
    // R11: write and lookup in one cycle sees old contents
    @(negedge clk);
    model(32'h1234_5678, 1'b0);
    lk_va = 32'h1234_5678; lk_user = 0; lk_req = 1;
    wr_en = 1; wr_sel = 0; wr_idx = 6'd5; wr_data = 32'h1234_5080; wr_tid = 8'h00;
    @(negedge clk);
    lk_req = 0; wr_en = 0;
    m_tag[5] = 32'h1234_5080; m_tid[5] = 8'h00;
    chk("R11", "old hit", 32'(rsp_hit), 1);
    check_resp("R11");
    look(32'h1234_5678, 1'b0, "R11");
    // R11: ID captured with tag write
    load(50, 32'h7000_0000, 1, 8'h77, 32'h0700_0000, 1'b0, 1'b0, 1);
    pid = 8'h77;
    look(32'h7000_0004, 1'b0, "R11");
    pid = 8'h00;
    look(32'h7000_0004, 1'b0, "R11");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule